// File: doc/BRIEF.md
# Channel Reset Controller

This block owns the reset and clock control of one module slot on a carrier. It keeps a 32-bit control word that the host writes and reads over a plain register port. From that word it drives an active-low reset pin toward the attached module, plus an active-low reset for the channel's own internal logic. It also hands the clock-select, clock-disable, activity-enable and bus-timeout settings to neighbouring logic.

Software has two ways to put the module into reset. The soft reset bit holds the pin low only while the bit is set, and it lets go as soon as the bit is cleared. The hard reset bit holds both the pin and the channel logic in reset. After the hard bit is cleared, a counter clocked by a reference tick keeps both resets asserted until a fixed number of ticks has passed, so the module always sees the minimum pulse it needs. The host reset takes priority over both bits. The live level of the pin is synchronised and read back as an inverted status bit.

Top module: `chan_rst_ctrl`

## Requirements
- R1: While rst_ni is low, every control bit reads 0, status bit 18 reads 1, mod_rst_no and chan_rst_no are low, and bus_to_limit_o is 63.
- R2: A write stores only bits 17, 16, 13, 12, 9, 8 and 7:0. Bits 31:19, 15:14 and 11:10 always read 0, and writes to them are ignored.
- R3: Bit 16 (soft reset) drives mod_rst_no low from the edge that stores a 1. Clearing bit 16 releases the pin at the edge that stores the 0.
- R4: Bit 17 (hard reset) drives both mod_rst_no and chan_rst_no low while it is set.
- R5: After bit 17 is cleared, both resets stay low until HOLD_TICKS cycles with tick_i high have been counted. They rise at the edge that counts the last tick. Ticks that arrive while bit 17 is still set are not counted.
- R6: If bit 17 is set again before the hold count finishes, the count starts over from HOLD_TICKS.
- R7: The soft reset never asserts chan_rst_no.
- R8: Bit 18 reads the inverse of the mod_rst_no level as captured by a two-flop synchroniser. It follows a change on the pin two clock edges later.
- R9: clk_sel_o, clk_dis_o and act_cnt_en_o follow bits 8, 9 and 13 respectively.
- R10: bus_to_limit_o is set by {bit 8, bit 12}: 00 gives 63, 01 gives 127, 10 gives 127, and 11 gives 255.
- R11: Asserting rst_ni in the middle of a hold count clears the count. After rst_ni is released, both resets rise at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Host bus reset, asynchronous, active low |
| tick_i | input | 1 | Reference tick, one cycle wide, that paces the hold count |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Control word read back, with the status in bit 18 |
| mod_rst_no | output | 1 | Reset pin to the module, active low |
| chan_rst_no | output | 1 | Reset for the channel's internal logic, active low |
| clk_sel_o | output | 1 | Module clock select: 0 is slow, 1 is fast |
| clk_dis_o | output | 1 | Module clock disable |
| act_cnt_en_o | output | 1 | Enable for the activity counter |
| bus_to_limit_o | output | 8 | Bus-error timeout count in module clocks |

## Verification
Register contents, the clock outputs and the timeout limit are due one edge after the write, because the only register on the path is the control word. The soft-reset pin follows in that same edge. The hard-reset release is due at the edge that counts the HOLD_TICKS-th tick, and the status bit lags the pin by two more edges. The bench drives every input on the falling edge and samples at the next falling edge after the edge it counts towards. For the hold count and the status lag, it checks the last cycle before the expected change as well as the cycle of the change itself.

// File: rtl/chan_rst_pkg.sv
package chan_rst_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned B_CSEL = 8;
  localparam int unsigned B_CDIS = 9;
  localparam int unsigned B_TSEL = 12;
  localparam int unsigned B_ACTE = 13;
  localparam int unsigned B_SOFT = 16;
  localparam int unsigned B_HARD = 17;
  localparam int unsigned B_STAT = 18;

  localparam logic [DW-1:0] WR_MASK = (DW'(1) << B_HARD) | (DW'(1) << B_SOFT)
                                    | (DW'(1) << B_ACTE) | (DW'(1) << B_TSEL)
                                    | (DW'(1) << B_CDIS) | (DW'(1) << B_CSEL)
                                    | DW'(8'hFF);

  // limit = 2^(6+fast+long) - 1
  function automatic logic [7:0] to_limit(logic fast, logic long_sel);
    logic [8:0] v;
    v = (9'd1 << (4'd6 + {3'd0, fast} + {3'd0, long_sel})) - 9'd1;
    return v[7:0];
  endfunction
endpackage

// File: rtl/chan_rst_regs.sv
module chan_rst_regs
  import chan_rst_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & WR_MASK;
  end

  assign ctrl_o = ctrl_q;

  a_r2_write_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_o == ($past(wdata_i) & WR_MASK));
  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/chan_rst_stretch.sv
module chan_rst_stretch #(
  parameter int unsigned HOLD_TICKS = 256,
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic tick_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (hold_i)                     cnt_q <= CW'(HOLD_TICKS);
    else if (tick_i && cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_q == CW'(HOLD_TICKS));
  a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HOLD_TICKS));
  a_r5_no_tick_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !tick_i) |=> $stable(cnt_q));
  a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && tick_i && busy_o) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/chan_rst_sync.sv
module chan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sh_q[0] <= 1'b0;
          else         sh_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sh_q[i] <= 1'b0;
          else         sh_q[i] <= sh_q[i-1];
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/chan_rst_ctrl.sv
module chan_rst_ctrl
  import chan_rst_pkg::*;
#(
  parameter int unsigned HOLD_TICKS  = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mod_rst_no,
  output logic          chan_rst_no,
  output logic          clk_sel_o,
  output logic          clk_dis_o,
  output logic          act_cnt_en_o,
  output logic [7:0]    bus_to_limit_o
);
  logic [DW-1:0] ctrl;
  logic          busy;
  logic          host_rel_q;
  logic          pin_lvl;

  chan_rst_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i), .ctrl_o(ctrl)
  );

  chan_rst_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_stretch (
    .clk_i, .rst_ni, .hold_i(ctrl[B_HARD]), .tick_i, .busy_o(busy)
  );

  // release of host reset takes effect on the first edge after deassertion
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) host_rel_q <= 1'b0;
    else         host_rel_q <= 1'b1;

  assign chan_rst_no = host_rel_q & ~ctrl[B_HARD] & ~busy;
  assign mod_rst_no  = chan_rst_no & ~ctrl[B_SOFT];

  chan_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(mod_rst_no), .q_o(pin_lvl)
  );

  always_comb begin
    reg_rdata_o         = ctrl;
    reg_rdata_o[B_STAT] = ~pin_lvl;
  end

  assign clk_sel_o      = ctrl[B_CSEL];
  assign clk_dis_o      = ctrl[B_CDIS];
  assign act_cnt_en_o   = ctrl[B_ACTE];
  assign bus_to_limit_o = to_limit(ctrl[B_CSEL], ctrl[B_TSEL]);

  a_r4_hard_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[B_HARD] |-> (!mod_rst_no && !chan_rst_no));
  a_r7_soft_no_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[B_SOFT] && !ctrl[B_HARD] && !busy && host_rel_q) |-> chan_rst_no);
  a_r5_release_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_rst_no) |-> !ctrl[B_HARD] && !busy);
  a_r8_status_lags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_rst_no) |=> reg_rdata_o[B_STAT]);
  a_r2_resv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~(WR_MASK | (DW'(1) << B_STAT))) == '0);
endmodule

// File: tb/chan_rst_ctrl_tb_top.sv
module chan_rst_ctrl_tb_top;
  localparam int unsigned HOLD = 8;
  localparam logic [31:0] MASK = 32'h0003_33FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mod_rst_n, chan_rst_n, csel, cdis, acte;
  logic [7:0]  tolim;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  chan_rst_ctrl #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mod_rst_no(mod_rst_n),
    .chan_rst_no(chan_rst_n), .clk_sel_o(csel), .clk_dis_o(cdis),
    .act_cnt_en_o(acte), .bus_to_limit_o(tolim)
  );

  function automatic logic [7:0] exp_limit(logic fast, logic long_sel);
    case ({fast, long_sel})
      2'b00:   return 8'd63;
      2'b01:   return 8'd127;
      2'b10:   return 8'd127;
      default: return 8'd255;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_tb();
  end

  initial begin
    logic [31:0] d, e;
    void'($urandom(32'd4242));
    idle(3);
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0004_0000);
    chk("R1 pin", {31'd0, mod_rst_n}, 0);
    chk("R1 chan", {31'd0, chan_rst_n}, 0);
    chk("R1 limit", {24'd0, tolim}, 63);
    @(negedge clk); rst_n = 1'b1;
    chk("R11 still low before edge", {31'd0, mod_rst_n}, 0);
    @(negedge clk);
    chk("R11 pin up after edge", {31'd0, mod_rst_n}, 1);
    idle(3);
    chk("R8 status idle", {31'd0, rdata[18]}, 0);

    // R2 reserved ignore
    wr(32'hFFFF_FFFF & ~32'h0003_0000);
    chk("R2 resv masked", rdata, 32'h0000_33FF);
    wr(32'h0000_0000);
    chk("R2 clear", rdata, 32'h0);

    // R3 soft reset and R8 status lag
    wr(32'h0001_0000);
    chk("R3 soft low", {31'd0, mod_rst_n}, 0);
    chk("R7 chan kept", {31'd0, chan_rst_n}, 1);
    chk("R8 lag1", {31'd0, rdata[18]}, 0);
    @(negedge clk);
    chk("R8 lag2", {31'd0, rdata[18]}, 0);
    @(negedge clk);
    chk("R8 status up", {31'd0, rdata[18]}, 1);
    pulse_tick();
    wr(32'h0);
    chk("R3 soft release", {31'd0, mod_rst_n}, 1);

    // R4/R5 hard reset with stretch
    wr(32'h0002_0000);
    chk("R4 pin low", {31'd0, mod_rst_n}, 0);
    chk("R4 chan low", {31'd0, chan_rst_n}, 0);
    pulse_tick(); pulse_tick();
    wr(32'h0);
    for (int i = 0; i < HOLD - 1; i++) begin
      idle(2);
      pulse_tick();
    end
    chk("R5 held before last tick", {31'd0, mod_rst_n}, 0);
    chk("R5 chan held", {31'd0, chan_rst_n}, 0);
    idle(3);
    chk("R5 no tick no release", {31'd0, mod_rst_n}, 0);
    pulse_tick();
    chk("R5 released pin", {31'd0, mod_rst_n}, 1);
    chk("R5 released chan", {31'd0, chan_rst_n}, 1);

    // R6 restart
    wr(32'h0002_0000);
    wr(32'h0);
    for (int i = 0; i < 4; i++) pulse_tick();
    wr(32'h0002_0000);
    wr(32'h0);
    for (int i = 0; i < HOLD - 1; i++) pulse_tick();
    chk("R6 restarted still low", {31'd0, mod_rst_n}, 0);
    pulse_tick();
    chk("R6 release after full count", {31'd0, mod_rst_n}, 1);

    // R11 host reset mid-count
    wr(32'h0002_0000);
    wr(32'h0);
    pulse_tick(); pulse_tick();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 regs cleared", rdata, 32'h0004_0000);
    chk("R11 pin low", {31'd0, mod_rst_n}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 count cleared", {31'd0, mod_rst_n}, 1);
    chk("R11 chan up", {31'd0, chan_rst_n}, 1);

    // R10 directed table
    wr(32'h0000_0000); chk("R10 00", {24'd0, tolim}, 63);
    wr(32'h0000_1000); chk("R10 01", {24'd0, tolim}, 127);
    wr(32'h0000_0100); chk("R10 10", {24'd0, tolim}, 127);
    wr(32'h0000_1100); chk("R10 11", {24'd0, tolim}, 255);

    // random register traffic, hard bit kept clear
    for (int n = 0; n < 60; n++) begin
      d = $urandom() & ~32'h0002_0000;
      wr(d);
      idle(2);
      e = (d & MASK) | (d[16] ? 32'h0004_0000 : 32'h0);
      chk("R2 rand readback", rdata, e);
      chk("R3 rand pin", {31'd0, mod_rst_n}, {31'd0, ~d[16]});
      chk("R7 rand chan", {31'd0, chan_rst_n}, 1);
      chk("R9 rand clk", {29'd0, acte, cdis, csel}, {29'd0, d[13], d[9], d[8]});
      chk("R10 rand limit", {24'd0, tolim}, {24'd0, exp_limit(d[8], d[12])});
    end
    finish_tb();
  end
endmodule